// File: doc/BRIEF.md
# Nested-Loop Multichannel DMA Controller

This block is the control core of a multichannel DMA engine. Every channel keeps a descriptor with two nested counters. The inner loop sets how many beats one activation moves. The outer loop sets how many activations make up the whole job. When channels are pending, the block picks one and runs exactly one inner loop for it. Each beat is a read from the source address followed by a write of the returned word to the destination address, both on a single request/response memory port. After every beat both addresses step by signed per-channel offsets.

When an inner loop finishes, the block writes the new addresses and iteration count back to the descriptor. If that was the final iteration, it adds signed adjustments to both addresses, reloads the iteration count, sets the channel's done flag and, when enabled, its interrupt flag. It can then make another channel pending. Two links are available: one used when iterations remain and one used after the final iteration. Software loads descriptors through a register write port and starts channels with a start pulse vector. The choice between fixed priority and round-robin is made by one input.

Top module: `dma_loop_ctrl`

## Requirements
- R1: Software writes a descriptor field of channel `cfg_ch` when `cfg_we` is high. `cfg_sel` picks the field: 0 source address, 1 destination address, 2 offsets (source offset in [15:0], destination offset in [31:16], both signed), 3 inner beat count [15:0], 4 outer iteration count [15:0] (loads both the start and the current value), 5 signed source adjustment, 6 signed destination adjustment, 7 control (bit 0 interrupt enable, bit 1 inner link enable, bit 2 outer link enable, [15:8] inner link target, [23:16] outer link target).
- R2: Each beat issues a read (`mem_we`=0) at the source address, waits for `mem_rvalid`, then issues a write (`mem_we`=1) of that returned word at the destination address. A request is held with a stable address until `mem_gnt` is high.
- R3: One activation moves the inner beat count of beats, and an inner count of 0 moves one beat. After each beat, source and destination addresses advance by their sign-extended 16-bit offsets. These addresses persist across activations.
- R4: Each activation uses one outer iteration. When the current count is 1 or 0, the activation is final. The adjustments are then added to the stepped addresses, the count is reloaded from its start value, and `ch_done` of the channel is set one cycle after its last write is granted.
- R5: A start pulse on `start_req[i]` makes channel i pending and clears `ch_done[i]` and `ch_irq[i]` on the same clock edge.
- R6: Once granted, a channel's inner loop runs to its end, and no other channel is granted until it does.
- R7: With `rr_mode`=0, the highest-numbered pending channel is granted.
- R8: With `rr_mode`=1, the search starts at the channel after the one granted last and wraps around.
- R9: When a non-final activation ends with the inner link enabled, the inner link target becomes pending and the outer link does not fire.
- R10: When a final activation ends with the outer link enabled, the outer link target becomes pending and the inner link does not fire.
- R11: A final activation sets `ch_irq` of the channel only when its interrupt enable is 1.
- R12: `ch_active[i]` is high from the cycle after channel i is granted until its inner loop ends, and is low otherwise, including after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_ch | input | CHW | Channel being written |
| cfg_sel | input | 3 | Field select (see R1) |
| cfg_wdata | input | 32 | Field value |
| start_req | input | NCH | Per-channel start pulses |
| rr_mode | input | 1 | 1 = round-robin, 0 = fixed priority |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ch_done | output | NCH | Outer loop completed flags |
| ch_active | output | NCH | Channel currently running an inner loop |
| ch_irq | output | NCH | Completion interrupt requests |

## Verification
The bench starts channels at the same time to check the grant order in both arbitration modes. A design that searched from the wrong end, or did not advance the round-robin pointer, would put writes in the wrong order. It starts a higher channel while a multi-beat inner loop is running. A design that pre-empts would place that channel's write between the first channel's beats. It runs descriptors with negative offsets, an inner count of zero and stalled grants, then starts one more activation after the final iteration. A wrong sign extension, a missing adjustment or a dropped reload of the count would show up as a wrong first write address in that activation. A linked pair is run through a non-final and a final activation, to catch a design that fires the wrong link or raises an interrupt for a channel whose enable is clear.

// File: rtl/dmalc_pkg.sv
package dmalc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int OFF_W  = 16;
  localparam int LINK_W = 8;

  typedef enum logic [2:0] {
    SEL_SRC = 3'd0, SEL_DST = 3'd1, SEL_OFFS = 3'd2, SEL_MINOR = 3'd3,
    SEL_MAJOR = 3'd4, SEL_SADJ = 3'd5, SEL_DADJ = 3'd6, SEL_CTRL = 3'd7
  } sel_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_RWAIT, ST_WR} st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [OFF_W-1:0]  soff;
    logic [OFF_W-1:0]  doff;
    logic [CNT_W-1:0]  nminor;
    logic [CNT_W-1:0]  biter;
    logic [CNT_W-1:0]  citer;
    logic [ADDR_W-1:0] sadj;
    logic [ADDR_W-1:0] dadj;
    logic              int_en;
    logic              mlink_en;
    logic              jlink_en;
    logic [LINK_W-1:0] mlink_ch;
    logic [LINK_W-1:0] jlink_ch;
  } desc_t;

  // Address plus sign-extended offset.
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [OFF_W-1:0] off);
    return a + ADDR_W'($signed(off));
  endfunction

  // Inner count of zero is run as a single beat.
  function automatic logic [CNT_W-1:0] beats_of(input logic [CNT_W-1:0] n);
    return (n == '0) ? CNT_W'(1) : n;
  endfunction

  // Current iteration count of 1 (or 0) marks the final activation.
  function automatic logic last_iter(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction
endpackage

// File: rtl/dmalc_desc_bank.sv
module dmalc_desc_bank
  import dmalc_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              upd_en,
  input  logic [CHW-1:0]    upd_ch,
  input  logic [ADDR_W-1:0] upd_src,
  input  logic [ADDR_W-1:0] upd_dst,
  input  logic [CNT_W-1:0]  upd_citer,
  input  logic [CHW-1:0]    rd_ch,
  output desc_t             rd_desc
);
  desc_t [NCH-1:0] bank;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    desc_t r_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_q <= '0;
      end else if (upd_en && upd_ch == CHW'(g)) begin
        r_q.src   <= upd_src;
        r_q.dst   <= upd_dst;
        r_q.citer <= upd_citer;
      end else if (cfg_we && cfg_ch == CHW'(g)) begin
        case (sel_e'(cfg_sel))
          SEL_SRC:   r_q.src <= cfg_wdata;
          SEL_DST:   r_q.dst <= cfg_wdata;
          SEL_OFFS:  begin r_q.soff <= cfg_wdata[15:0]; r_q.doff <= cfg_wdata[31:16]; end
          SEL_MINOR: r_q.nminor <= cfg_wdata[CNT_W-1:0];
          SEL_MAJOR: begin r_q.biter <= cfg_wdata[CNT_W-1:0]; r_q.citer <= cfg_wdata[CNT_W-1:0]; end
          SEL_SADJ:  r_q.sadj <= cfg_wdata;
          SEL_DADJ:  r_q.dadj <= cfg_wdata;
          default: begin
            r_q.int_en   <= cfg_wdata[0];
            r_q.mlink_en <= cfg_wdata[1];
            r_q.jlink_en <= cfg_wdata[2];
            r_q.mlink_ch <= cfg_wdata[15:8];
            r_q.jlink_ch <= cfg_wdata[23:16];
          end
        endcase
      end
    end
    assign bank[g] = r_q;
  end

  assign rd_desc = bank[rd_ch];

  // R1: a source write lands in the addressed channel
  a_r1_src_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 3'(SEL_SRC) && !upd_en)
      |=> bank[$past(cfg_ch)].src == $past(cfg_wdata));
endmodule

// File: rtl/dmalc_arb.sv
module dmalc_arb #(
  parameter int NCH = 16,
  parameter int CHW = 4
) (
  input  logic [NCH-1:0] pend,
  input  logic           rr_mode,
  input  logic [CHW-1:0] last_ch,
  output logic           any,
  output logic [CHW-1:0] win_ch
);
  function automatic logic [CHW-1:0] pick_hi(input logic [NCH-1:0] p);
    logic [CHW-1:0] w;
    w = '0;
    for (int i = 0; i < NCH; i++) if (p[i]) w = CHW'(i);
    return w;
  endfunction

  function automatic logic [CHW-1:0] pick_rr(input logic [NCH-1:0] p,
                                             input logic [CHW-1:0] last);
    logic [CHW-1:0] w;
    logic found;
    int idx;
    w = '0;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      idx = (int'(last) + k) % NCH;
      if (!found && p[idx]) begin
        w = CHW'(idx);
        found = 1'b1;
      end
    end
    return w;
  endfunction

  assign any    = |pend;
  assign win_ch = rr_mode ? pick_rr(pend, last_ch) : pick_hi(pend);
endmodule

// File: rtl/dmalc_mover.sv
module dmalc_mover
  import dmalc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  desc_t             go_desc,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              seg_end,
  output logic              seg_final,
  output desc_t             run_desc,
  output logic [ADDR_W-1:0] wb_src,
  output logic [ADDR_W-1:0] wb_dst,
  output logic [CNT_W-1:0]  wb_citer
);
  st_e               st_q;
  desc_t             d_q;
  logic [ADDR_W-1:0] src_q, dst_q, nxt_src, nxt_dst;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  left_q;
  logic              beat_done;

  assign nxt_src   = step_addr(src_q, d_q.soff);
  assign nxt_dst   = step_addr(dst_q, d_q.doff);
  assign beat_done = (st_q == ST_WR) && mem_gnt;
  assign seg_end   = beat_done && left_q == CNT_W'(1);
  assign seg_final = last_iter(d_q.citer);
  assign wb_src    = seg_final ? nxt_src + d_q.sadj : nxt_src;
  assign wb_dst    = seg_final ? nxt_dst + d_q.dadj : nxt_dst;
  assign wb_citer  = seg_final ? d_q.biter : d_q.citer - CNT_W'(1);
  assign run_desc  = d_q;

  assign idle      = (st_q == ST_IDLE);
  assign mem_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? dst_q : src_q;
  assign mem_wdata = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      d_q    <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      left_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          d_q    <= go_desc;
          src_q  <= go_desc.src;
          dst_q  <= go_desc.dst;
          left_q <= beats_of(go_desc.nminor);
          st_q   <= ST_RD;
        end
        ST_RD: if (mem_gnt) st_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          st_q   <= ST_WR;
        end
        default: if (mem_gnt) begin
          src_q <= nxt_src;
          dst_q <= nxt_dst;
          if (left_q == CNT_W'(1)) st_q <= ST_IDLE;
          else begin
            left_q <= left_q - CNT_W'(1);
            st_q   <= ST_RD;
          end
        end
      endcase
    end
  end

  // R2: an ungranted request holds its kind and address
  a_r2_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
  // R2: returned read data is what the next write carries
  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RWAIT && mem_rvalid) |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata)));
endmodule

// File: rtl/dma_loop_ctrl.sv
module dma_loop_ctrl
  import dmalc_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [NCH-1:0]    start_req,
  input  logic              rr_mode,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [NCH-1:0]    ch_done,
  output logic [NCH-1:0]    ch_active,
  output logic [NCH-1:0]    ch_irq
);
  function automatic logic [NCH-1:0] ch_bit(input logic [CHW-1:0] c);
    return NCH'(1) << c;
  endfunction

  function automatic logic link_ok(input logic [LINK_W-1:0] t);
    return t < LINK_W'(NCH);
  endfunction

  logic [NCH-1:0]    pend_q, done_q, irq_q, link_vec, grant_vec, fin_vec;
  logic [CHW-1:0]    cur_ch_q, arb_win;
  logic              arb_any, grant, mv_idle, seg_end, seg_final;
  desc_t             sel_desc, run_desc;
  logic [ADDR_W-1:0] wb_src, wb_dst;
  logic [CNT_W-1:0]  wb_citer;

  dmalc_desc_bank #(.NCH(NCH), .CHW(CHW)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .upd_en(seg_end), .upd_ch(cur_ch_q), .upd_src(wb_src), .upd_dst(wb_dst),
    .upd_citer(wb_citer), .rd_ch(arb_win), .rd_desc(sel_desc)
  );

  dmalc_arb #(.NCH(NCH), .CHW(CHW)) arb_i (
    .pend(pend_q), .rr_mode(rr_mode), .last_ch(cur_ch_q),
    .any(arb_any), .win_ch(arb_win)
  );

  dmalc_mover mover_i (
    .clk(clk), .rst_n(rst_n), .go(grant), .go_desc(sel_desc), .idle(mv_idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .seg_end(seg_end), .seg_final(seg_final), .run_desc(run_desc),
    .wb_src(wb_src), .wb_dst(wb_dst), .wb_citer(wb_citer)
  );

  assign grant     = mv_idle && arb_any;
  assign grant_vec = grant ? ch_bit(arb_win) : '0;
  assign fin_vec   = (seg_end && seg_final) ? ch_bit(cur_ch_q) : '0;

  always_comb begin
    link_vec = '0;
    if (seg_end) begin
      if (seg_final && run_desc.jlink_en && link_ok(run_desc.jlink_ch))
        link_vec = ch_bit(run_desc.jlink_ch[CHW-1:0]);
      else if (!seg_final && run_desc.mlink_en && link_ok(run_desc.mlink_ch))
        link_vec = ch_bit(run_desc.mlink_ch[CHW-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= '0;
      done_q   <= '0;
      irq_q    <= '0;
      cur_ch_q <= '0;
    end else begin
      pend_q <= (pend_q & ~grant_vec) | start_req | link_vec;
      done_q <= (done_q & ~start_req) | fin_vec;
      irq_q  <= (irq_q & ~start_req) | (run_desc.int_en ? fin_vec : '0);
      if (grant) cur_ch_q <= arb_win;
    end
  end

  assign ch_done   = done_q;
  assign ch_irq    = irq_q;
  assign ch_active = mv_idle ? '0 : ch_bit(cur_ch_q);

  // R6: the running channel does not change until its inner loop ends
  a_r6_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_active != '0 && !seg_end) |=> $stable(ch_active));
  // R7: fixed priority grants the highest pending channel
  a_r7_fixed_highest: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !rr_mode) |-> ((pend_q >> arb_win) == NCH'(1)));
  // R4: the final activation raises done
  a_r4_done_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && seg_final) |=> ch_done[$past(cur_ch_q)]);
  // R9: a non-final activation with its inner link on makes the target pending
  a_r9_minor_link: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_end && !seg_final && run_desc.mlink_en && link_ok(run_desc.mlink_ch))
      |=> pend_q[$past(run_desc.mlink_ch[CHW-1:0])]);
endmodule

// File: tb/dma_loop_ctrl_tb_top.sv
module dma_loop_ctrl_tb_top;
  localparam int NCH = 16;
  localparam int CHW = 4;
  localparam logic [31:0] KEY = 32'h5A5A_0000;
  // {soff, doff, inner count, outer count, sadj16, dadj16}
  localparam logic [79:0] VEC [4] = '{
    80'h0004_0004_03_02_FFE8_FFE8,
    80'hFFFC_0008_02_01_0010_FFF0,
    80'h0000_0004_00_03_0000_0100,
    80'h000C_FFF8_04_01_FFD0_0040
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NCH-1:0] start_req = '0;
  logic rr_mode = 0;
  logic mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_gnt = 1, mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;
  logic [NCH-1:0] ch_done, ch_active, ch_irq;

  int checks = 0, fails = 0, wl_n = 0, cyc_n = 0;
  logic [31:0] wl_addr [0:255];
  logic [31:0] wl_data [0:255];
  logic stall = 0, rd_pend = 0, finished = 0;
  logic [31:0] rd_addr = '0;

  always #2.5 clk = ~clk;

  dma_loop_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start_req(start_req), .rr_mode(rr_mode),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ch_done(ch_done), .ch_active(ch_active), .ch_irq(ch_irq)
  );

  // Memory model, acting between clock edges
  always @(negedge clk) begin
    logic g;
    cyc_n++;
    if (rd_pend) begin
      mem_rvalid = 1;
      mem_rdata  = rd_addr ^ KEY;
      rd_pend    = 0;
    end else mem_rvalid = 0;
    g = stall ? (cyc_n % 3 != 0) : 1'b1;
    mem_gnt = g;
    if (mem_req && g) begin
      if (mem_we) begin
        if (wl_n < 256) begin
          wl_addr[wl_n] = mem_addr;
          wl_data[wl_n] = mem_wdata;
        end
        wl_n++;
      end else begin
        rd_pend = 1;
        rd_addr = mem_addr;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = CHW'(ch); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic prog(input int ch, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] so, input logic [15:0] dof, input int n,
                      input int m, input logic [31:0] sa, input logic [31:0] da,
                      input logic [31:0] ctl);
    cfg(ch, 0, s); cfg(ch, 1, d); cfg(ch, 2, {dof, so}); cfg(ch, 3, 32'(n));
    cfg(ch, 4, 32'(m)); cfg(ch, 5, sa); cfg(ch, 6, da); cfg(ch, 7, ctl);
  endtask

  task automatic pulse(input logic [NCH-1:0] mask);
    @(negedge clk);
    start_req = mask;
    @(negedge clk);
    start_req = '0;
  endtask

  task automatic quiet();
    int q = 0, guard = 0;
    while (q < 8 && guard < 3000) begin
      @(negedge clk);
      if (ch_active == '0) q++; else q = 0;
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R2 reset mem_req", 32'(mem_req), 0);
    chk("R12 reset active", 32'(ch_active), 0);
    chk("R4 reset done", 32'(ch_done), 0);
    chk("R11 reset irq", 32'(ch_irq), 0);
    rst_n = 1;

    // Vector walk on channel 3
    for (int i = 0; i < 4; i++) begin
      logic [31:0] s, d, sa, da, es, ed;
      int so, dof, n, m, eff;
      so  = int'($signed(VEC[i][79:64]));
      dof = int'($signed(VEC[i][63:48]));
      n   = int'(VEC[i][47:40]);
      m   = int'(VEC[i][39:32]);
      sa  = 32'($signed(VEC[i][31:16]));
      da  = 32'($signed(VEC[i][15:0]));
      eff = (n == 0) ? 1 : n;
      s   = 32'h0100_0000 + 32'(i) * 32'h1000;
      d   = 32'h0030_8000;
      stall = (i % 2 == 1);
      prog(3, s, d, VEC[i][79:64], VEC[i][63:48], n, m, sa, da, 32'h0);
      wl_n = 0;
      for (int k = 0; k < m; k++) begin
        pulse(NCH'(1) << 3);
        quiet();
        if (k == 0 && m > 1) chk("R4 done low before final", 32'(ch_done[3]), 0);
      end
      chk("R3 beat count", 32'(wl_n), 32'(m * eff));
      for (int j = 0; j < m * eff; j++) begin
        es = s + 32'(j * so);
        ed = d + 32'(j * dof);
        chk("R3 write address", wl_addr[j], ed);
        chk("R1 R2 write data from source", wl_data[j], es ^ KEY);
      end
      chk("R4 done after final", 32'(ch_done[3]), 1);
      wl_n = 0;
      pulse(NCH'(1) << 3);
      quiet();
      chk("R4 adjusted dst", wl_addr[0], d + 32'(m * eff * dof) + da);
      chk("R4 adjusted src", wl_data[0], (s + 32'(m * eff * so) + sa) ^ KEY);
    end
    stall = 0;

    // Fixed priority
    prog(2, 32'h0200_0000, 32'h0020_0000, 16'h4, 16'h4, 1, 1, 0, 0, 0);
    prog(5, 32'h0500_0000, 32'h0050_0000, 16'h4, 16'h4, 1, 1, 0, 0, 0);
    prog(9, 32'h0900_0000, 32'h0090_0000, 16'h4, 16'h4, 1, 1, 0, 0, 0);
    rr_mode = 0;
    wl_n = 0;
    pulse((NCH'(1) << 2) | (NCH'(1) << 5));
    quiet();
    chk("R7 first grant", 32'(wl_addr[0][23:20]), 5);
    chk("R7 second grant", 32'(wl_addr[1][23:20]), 2);

    // Round-robin, last granted is channel 2
    rr_mode = 1;
    wl_n = 0;
    pulse((NCH'(1) << 2) | (NCH'(1) << 5) | (NCH'(1) << 9));
    chk("R5 start clears done", 32'(ch_done[2]), 0);
    quiet();
    chk("R8 rr first", 32'(wl_addr[0][23:20]), 5);
    chk("R8 rr second", 32'(wl_addr[1][23:20]), 9);
    chk("R8 rr third", 32'(wl_addr[2][23:20]), 2);
    rr_mode = 0;

    // No pre-emption of a running inner loop
    prog(2, 32'h0200_0000, 32'h0020_0000, 16'h4, 16'h4, 3, 1, 0, 0, 0);
    wl_n = 0;
    pulse(NCH'(1) << 2);
    @(negedge clk);
    pulse(NCH'(1) << 9);
    quiet();
    chk("R6 beat 1 owner", 32'(wl_addr[1][23:20]), 2);
    chk("R6 beat 2 owner", 32'(wl_addr[2][23:20]), 2);
    chk("R6 late channel last", 32'(wl_addr[3][23:20]), 9);

    // Links and interrupts
    prog(1, 32'h0100_8000, 32'h0010_0000, 16'h4, 16'h4, 1, 2, 0, 0, 32'h0007_0607);
    prog(6, 32'h0600_0000, 32'h0060_0000, 16'h4, 16'h4, 1, 1, 0, 0, 0);
    prog(7, 32'h0700_0000, 32'h0070_0000, 16'h4, 16'h4, 1, 1, 0, 0, 0);
    wl_n = 0;
    pulse(NCH'(1) << 1);
    @(negedge clk);
    chk("R12 active while running", 32'(ch_active), 32'h2);
    quiet();
    chk("R9 write count", 32'(wl_n), 2);
    chk("R9 inner link target", 32'(wl_addr[1][23:20]), 6);
    chk("R11 no irq before final", 32'(ch_irq[1]), 0);
    wl_n = 0;
    pulse(NCH'(1) << 1);
    quiet();
    chk("R10 write count", 32'(wl_n), 2);
    chk("R10 outer link target", 32'(wl_addr[1][23:20]), 7);
    chk("R11 irq on final", 32'(ch_irq[1]), 1);
    chk("R11 no irq when disabled", 32'(ch_irq[7]), 0);
    chk("R4 linked channel done", 32'(ch_done[7]), 1);
    chk("R12 idle afterwards", 32'(ch_active), 0);
    pulse(NCH'(1) << 1);
    chk("R5 start clears irq", 32'(ch_irq[1]), 0);
    quiet();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule